// File: doc/BRIEF.md
# Upset-Hardened Scrubbed FIFO

This block is a synchronous first-in first-out buffer for logic that runs in an ionising-radiation environment. Each 16-bit word is stored with Hamming check bits plus one overall parity bit, so a read returns corrected data when one bit has flipped and raises a flag when two have. A host read never writes the storage back. Instead, on every cycle with no host transfer, a background scrubber visits one occupied entry and rewrites it if it holds a correctable error. This keeps single upsets from piling up into uncorrectable ones.

Two saturating counters report what was found: one counts corrected single-bit errors and the other counts detected double-bit errors. A synchronous clear input resets both. The write pointer, the read pointer and the scrub pointer are each held in three copies. The block uses the bitwise majority of the three, and every copy is reloaded with the voted next value on every cycle, so an upset in one copy is repaired on the following cycle.

Both sides use a data-valid / get-data handshake. On the write side the producer raises `wr_valid` and the FIFO answers with `wr_get`. On the read side the FIFO raises `rd_valid` and the consumer answers with `rd_get`. Upset-injection inputs flip chosen bits in one storage entry or in one copy of the write and read pointers, so that strikes can be modelled.

Top module: `seu_fifo`

## Requirements
- R1: After reset, `rd_valid` is 0, `wr_get` is 1, and `sec_cnt` and `ded_cnt` are both 0.
- R2: `wr_get` is 1 while fewer than DEPTH (16) words are held. A word is accepted on a rising edge where `wr_valid` and `wr_get` are both 1. `wr_valid` asserted while `wr_get` is 0 changes nothing.
- R3: `rd_valid` is 1 while the FIFO holds at least one word, and `rd_data` then shows the oldest word. That word is removed on a rising edge where `rd_valid` and `rd_get` are both 1. Words leave in the order they were accepted, also when a write and a read happen in the same cycle.
- R4: Each word is stored as a 22-bit codeword. The n-th word accepted since reset (counting from 0) occupies storage address n mod DEPTH. While `inj_mem_en` is 1, the entry at `inj_addr` is XORed with `inj_mask` at the rising edge.
- R5: When the head entry has one flipped bit, `rd_data` shows the original word and `rd_uncorr` is 0. Reading that word raises `sec_cnt` by one, visible after the read edge.
- R6: When the head entry has two flipped bits, `rd_uncorr` is 1 while it is shown. Reading it raises `ded_cnt` by one, visible after the read edge.
- R7: On each cycle with no host transfer and a non-empty FIFO, the scrubber checks one occupied entry. It moves through the entries in address order and wraps back to the oldest one. An entry with one flipped bit is rewritten corrected and `sec_cnt` rises by one. After DEPTH or more such cycles the stored error is gone, so a later read of that word does not count again.
- R8: The scrubber leaves an entry with two flipped bits unchanged and raises `ded_cnt` by one on each visit to it.
- R9: Each counter is CNT_W (8) bits wide and holds at 255 rather than wrapping.
- R10: When `cnt_clr` is 1 at a rising edge, both counters are 0 after that edge, even if an error is counted in the same cycle.
- R11: An upset in one copy of the write or read pointer (`inj_ptr_en` with `inj_ptr_mask`) changes neither the stored data nor the order of reads. All three copies agree again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Producer has a word on `wr_data` |
| wr_data | input | 16 | Word to write |
| wr_get | output | 1 | FIFO can take a word (not full) |
| rd_valid | output | 1 | FIFO holds a word (not empty) |
| rd_data | output | 16 | Corrected oldest word |
| rd_uncorr | output | 1 | Oldest word has an uncorrectable error |
| rd_get | input | 1 | Consumer takes the shown word |
| cnt_clr | input | 1 | Synchronous clear of both error counters |
| sec_cnt | output | 8 | Corrected single-bit error count |
| ded_cnt | output | 8 | Detected double-bit error count |
| inj_mem_en | input | 1 | Apply a storage upset |
| inj_addr | input | 4 | Storage entry to upset |
| inj_mask | input | 22 | Bits of the codeword to flip |
| inj_ptr_en | input | 1 | Apply a pointer-copy upset |
| inj_ptr_mask | input | 5 | Bits to flip in copy 0 of the write and read pointers |

## Verification
The flags and the output word come from the current storage and the voted pointers through logic with no register on the way. They are therefore checked in the same cycle as the input change, half a period before the edge that would consume them. Counter updates pass through one register, so the bench samples them at the falling edge that follows the read, scrub or clear edge. The bench places each storage upset in a cycle that has no host transfer and reads the word on the next cycle. Scrub results are checked only after at least 2·DEPTH idle cycles, which makes the expected counter values exact.

// File: rtl/seu_fifo_pkg.sv
package seu_fifo_pkg;

  typedef enum logic [1:0] {
    ECC_CLEAN = 2'd0,
    ECC_FIXED = 2'd1,
    ECC_FATAL = 2'd2
  } ecc_stat_e;

  // number of Hamming check bits for a given data width
  function automatic int unsigned hamming_par(input int unsigned dw);
    int unsigned p;
    p = 0;
    while ((1 << p) < (dw + p + 1)) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int unsigned v);
    return (v & (v - 1)) == 0;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import seu_fifo_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0]                    data_i,
  output logic [DW+hamming_par(DW):0]      cw_o
);

  localparam int unsigned P    = hamming_par(DW);
  localparam int unsigned LAST = DW + P;

  logic [LAST:0] c;

  always_comb begin
    int j;
    logic p;
    c = '0;
    j = 0;
    for (int i = 1; i <= LAST; i++) begin
      if (!is_pow2(i)) begin
        c[i] = data_i[j];
        j++;
      end
    end
    for (int k = 0; k < P; k++) begin
      p = 1'b0;
      for (int i = 1; i <= LAST; i++) begin
        if (((i >> k) & 1) != 0 && !is_pow2(i)) p = p ^ c[i];
      end
      c[1 << k] = p;
    end
    c[0] = ^c[LAST:1];
  end

  assign cw_o = c;

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import seu_fifo_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW+hamming_par(DW):0]      cw_i,
  output logic [DW-1:0]                    data_o,
  output ecc_stat_e                        stat_o
);

  localparam int unsigned P    = hamming_par(DW);
  localparam int unsigned LAST = DW + P;

  logic [P-1:0] syn;
  logic         ov;
  logic         flip;

  always_comb begin
    syn = '0;
    for (int k = 0; k < P; k++) begin
      for (int i = 1; i <= LAST; i++) begin
        if (((i >> k) & 1) != 0) syn[k] = syn[k] ^ cw_i[i];
      end
    end
    ov = ^cw_i;
  end

  always_comb begin
    flip   = 1'b0;
    stat_o = ECC_CLEAN;
    if (ov) begin
      if (syn <= P'(LAST)) begin
        flip   = 1'b1;
        stat_o = ECC_FIXED;
      end else begin
        stat_o = ECC_FATAL;
      end
    end else if (syn != '0) begin
      stat_o = ECC_FATAL;
    end
  end

  always_comb begin
    int j;
    data_o = '0;
    j = 0;
    for (int i = 1; i <= LAST; i++) begin
      if (!is_pow2(i)) begin
        data_o[j] = cw_i[i] ^ (flip && (syn == P'(i)));
        j++;
      end
    end
  end

endmodule

// File: rtl/tmr_reg.sv
module tmr_reg #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] upset_i,
  output logic [W-1:0] q_o,
  output logic         mismatch_o
);

  for (genvar g = 0; g < 3; g++) begin : g_cp
    logic [W-1:0] q;
    logic [W-1:0] d;
    if (g == 0) begin : g_hit
      assign d = d_i ^ upset_i;
    end else begin : g_clean
      assign d = d_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end

  assign q_o = (g_cp[0].q & g_cp[1].q) |
               (g_cp[0].q & g_cp[2].q) |
               (g_cp[1].q & g_cp[2].q);

  assign mismatch_o = (g_cp[0].q != g_cp[1].q) || (g_cp[1].q != g_cp[2].q);

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i || (inc_i && (cnt_q != '1));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/seu_fifo.sv
module seu_fifo
  import seu_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_valid,
  input  logic [DATA_W-1:0]                      wr_data,
  output logic                                   wr_get,
  output logic                                   rd_valid,
  output logic [DATA_W-1:0]                      rd_data,
  output logic                                   rd_uncorr,
  input  logic                                   rd_get,
  input  logic                                   cnt_clr,
  output logic [CNT_W-1:0]                       sec_cnt,
  output logic [CNT_W-1:0]                       ded_cnt,
  input  logic                                   inj_mem_en,
  input  logic [$clog2(DEPTH)-1:0]               inj_addr,
  input  logic [DATA_W+hamming_par(DATA_W):0]    inj_mask,
  input  logic                                   inj_ptr_en,
  input  logic [$clog2(DEPTH):0]                 inj_ptr_mask
);

  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned PW   = AW + 1;
  localparam int unsigned CW_W = DATA_W + hamming_par(DATA_W) + 1;

  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // voted pointers
  logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [AW-1:0] sc_ptr, sc_nxt;
  logic [PW-1:0] ptr_upset;
  logic          wr_mis, rd_mis, sc_mis;

  assign ptr_upset = inj_ptr_en ? inj_ptr_mask : '0;

  tmr_reg #(.W(PW)) u_wr_ptr (
    .clk(clk), .rst_n(rst_int_n), .d_i(wr_nxt), .upset_i(ptr_upset),
    .q_o(wr_ptr), .mismatch_o(wr_mis)
  );

  tmr_reg #(.W(PW)) u_rd_ptr (
    .clk(clk), .rst_n(rst_int_n), .d_i(rd_nxt), .upset_i(ptr_upset),
    .q_o(rd_ptr), .mismatch_o(rd_mis)
  );

  tmr_reg #(.W(AW)) u_sc_ptr (
    .clk(clk), .rst_n(rst_int_n), .d_i(sc_nxt), .upset_i('0),
    .q_o(sc_ptr), .mismatch_o(sc_mis)
  );

  // occupancy and handshakes
  logic [PW-1:0] fill;
  logic          full, empty, wr_fire, rd_fire;
  logic [AW-1:0] wr_addr, rd_addr;

  always_comb begin
    fill    = wr_ptr - rd_ptr;
    full    = (fill == PW'(DEPTH));
    empty   = (fill == '0);
    wr_fire = wr_valid && !full;
    rd_fire = rd_get && !empty;
    wr_addr = wr_ptr[AW-1:0];
    rd_addr = rd_ptr[AW-1:0];
    wr_nxt  = wr_ptr + {{(PW-1){1'b0}}, wr_fire};
    rd_nxt  = rd_ptr + {{(PW-1){1'b0}}, rd_fire};
  end

  assign wr_get   = !full;
  assign rd_valid = !empty;

  // scrub sequencer: idle cycles only, occupied entries only
  logic [AW-1:0] sc_off, sc_addr;
  logic          sc_in_rng, sc_en;

  always_comb begin
    sc_en     = !wr_fire && !rd_fire && !empty;
    sc_off    = sc_ptr - rd_addr;
    sc_in_rng = ({1'b0, sc_off} < fill);
    sc_addr   = sc_in_rng ? sc_ptr : rd_addr;
    sc_nxt    = sc_en ? sc_addr + 1'b1 : sc_ptr;
  end

  // storage and codecs
  logic [CW_W-1:0]   mem [DEPTH];
  logic [CW_W-1:0]   wr_cw, sc_cw;
  logic [DATA_W-1:0] sc_data;
  ecc_stat_e         rd_stat, sc_stat;
  logic              sc_fix;

  secded_enc #(.DW(DATA_W)) u_wr_enc (.data_i(wr_data), .cw_o(wr_cw));

  secded_dec #(.DW(DATA_W)) u_rd_dec (
    .cw_i(mem[rd_addr]), .data_o(rd_data), .stat_o(rd_stat)
  );

  secded_dec #(.DW(DATA_W)) u_sc_dec (
    .cw_i(mem[sc_addr]), .data_o(sc_data), .stat_o(sc_stat)
  );

  secded_enc #(.DW(DATA_W)) u_sc_enc (.data_i(sc_data), .cw_o(sc_cw));

  assign sc_fix    = sc_en && (sc_stat == ECC_FIXED) && !sc_mis;
  assign rd_uncorr = rd_valid && (rd_stat == ECC_FATAL);

  always_ff @(posedge clk) begin
    if (wr_fire)    mem[wr_addr]  <= wr_cw;
    if (sc_fix)     mem[sc_addr]  <= sc_cw;
    if (inj_mem_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
  end

  // error counters
  logic sec_inc, ded_inc;

  assign sec_inc = (rd_fire && (rd_stat == ECC_FIXED)) || sc_fix;
  assign ded_inc = (rd_fire && (rd_stat == ECC_FATAL)) ||
                   (sc_en && (sc_stat == ECC_FATAL));

  sat_counter #(.W(CNT_W)) u_sec_cnt (
    .clk(clk), .rst_n(rst_int_n), .clr_i(cnt_clr), .inc_i(sec_inc), .cnt_o(sec_cnt)
  );

  sat_counter #(.W(CNT_W)) u_ded_cnt (
    .clk(clk), .rst_n(rst_int_n), .clr_i(cnt_clr), .inc_i(ded_inc), .cnt_o(ded_cnt)
  );

endmodule

// File: rtl/seu_fifo_chk.sv
module seu_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [$clog2(DEPTH):0]     wr_ptr,
  input logic [$clog2(DEPTH):0]     rd_ptr,
  input logic                       wr_mis,
  input logic                       rd_mis,
  input logic                       inj_ptr_en,
  input logic                       cnt_clr,
  input logic [CNT_W-1:0]           sec_cnt,
  input logic [CNT_W-1:0]           ded_cnt,
  input logic                       rd_valid,
  input logic                       wr_get
);

  localparam int unsigned PW = $clog2(DEPTH) + 1;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(wr_ptr - rd_ptr) <= PW'(DEPTH));

  // R1
  empty_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> wr_get);

  // R11
  tmr_repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(inj_ptr_en) |-> (!wr_mis && !rd_mis));

  // R9
  sec_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_cnt == '1 && !cnt_clr) |=> sec_cnt == '1);

  // R9
  ded_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ded_cnt == '1 && !cnt_clr) |=> ded_cnt == '1);

  // R10
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (sec_cnt == '0 && ded_cnt == '0));

  // R9
  sec_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> sec_cnt >= $past(sec_cnt));

endmodule

bind seu_fifo seu_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .wr_mis(wr_mis), .rd_mis(rd_mis), .inj_ptr_en(inj_ptr_en),
  .cnt_clr(cnt_clr), .sec_cnt(sec_cnt), .ded_cnt(ded_cnt),
  .rd_valid(rd_valid), .wr_get(wr_get)
);

// File: tb/test_seu_fifo.sv
module test_seu_fifo;

  localparam int DEPTH = 16;

  logic        clk, rst_n;
  logic        wr_valid, wr_get, rd_valid, rd_uncorr, rd_get, cnt_clr;
  logic [15:0] wr_data, rd_data;
  logic [7:0]  sec_cnt, ded_cnt;
  logic        inj_mem_en, inj_ptr_en;
  logic [3:0]  inj_addr;
  logic [21:0] inj_mask;
  logic [4:0]  inj_ptr_mask;

  int n_run, n_fail, n_wr;
  logic [15:0] q[$];

  seu_fifo i_seu_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_get(wr_get), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_uncorr(rd_uncorr), .rd_get(rd_get), .cnt_clr(cnt_clr),
    .sec_cnt(sec_cnt), .ded_cnt(ded_cnt), .inj_mem_en(inj_mem_en),
    .inj_addr(inj_addr), .inj_mask(inj_mask), .inj_ptr_en(inj_ptr_en),
    .inj_ptr_mask(inj_ptr_mask)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    tick();
    wr_valid = 1'b0;
    q.push_back(d);
    n_wr++;
  endtask

  task automatic pop_chk(input string req, input bit chk_data, input bit exp_unc);
    logic [15:0] e;
    e = q.pop_front();
    #1;
    chk({req, " valid"}, int'(rd_valid), 1);
    if (chk_data) chk({req, " data"}, int'(rd_data), int'(e));
    chk({req, " uncorr"}, int'(rd_uncorr), int'(exp_unc));
    rd_get = 1'b1;
    tick();
    rd_get = 1'b0;
  endtask

  task automatic inject(input int addr, input logic [21:0] m);
    inj_mem_en = 1'b1;
    inj_addr   = 4'(addr);
    inj_mask   = m;
    tick();
    inj_mem_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // R1
  task automatic t_reset();
    #1;
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 wr_get", int'(wr_get), 1);
    chk("R1 sec_cnt", int'(sec_cnt), 0);
    chk("R1 ded_cnt", int'(ded_cnt), 0);
  endtask

  // R2, R3: fill to capacity, refused write, drain in order
  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) push(16'hA500 + 16'(i * 7));
    #1;
    chk("R2 full wr_get", int'(wr_get), 0);
    wr_valid = 1'b1;
    wr_data  = 16'hDEAD;
    tick();
    wr_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) pop_chk("R3 drain", 1'b1, 1'b0);
    #1;
    chk("R2 refused write absent", int'(rd_valid), 0);
  endtask

  // R3: simultaneous write and read with pointer wraparound
  task automatic t_stream();
    push(16'h1111);
    push(16'h2222);
    for (int i = 0; i < 40; i++) begin
      logic [15:0] e;
      e = q.pop_front();
      wr_valid = 1'b1;
      wr_data  = 16'(i * 16'h0313) ^ 16'h5A5A;
      rd_get   = 1'b1;
      #1;
      chk("R3 stream data", int'(rd_data), int'(e));
      q.push_back(wr_data);
      n_wr++;
      tick();
      wr_valid = 1'b0;
      rd_get   = 1'b0;
    end
    pop_chk("R3 stream tail", 1'b1, 1'b0);
    pop_chk("R3 stream tail", 1'b1, 1'b0);
  endtask

  // R4, R5: single flip corrected on the read path
  task automatic t_sec_read();
    int base;
    int s0;
    base = n_wr;
    push(16'hC0DE);
    push(16'h0F0F);
    push(16'h8001);
    s0 = int'(sec_cnt);
    inject(base % DEPTH, 22'h000001);
    pop_chk("R5 parity bit flip", 1'b1, 1'b0);
    chk("R5 sec_cnt after read", int'(sec_cnt), s0 + 1);
    inject((base + 1) % DEPTH, 22'h002000);
    pop_chk("R4 R5 data bit flip", 1'b1, 1'b0);
    chk("R5 sec_cnt second", int'(sec_cnt), s0 + 2);
    pop_chk("R5 clean word", 1'b1, 1'b0);
    chk("R5 clean no count", int'(sec_cnt), s0 + 2);
  endtask

  // R6: double flip flagged on the read path
  task automatic t_ded_read();
    int base;
    int d0;
    base = n_wr;
    push(16'h3C3C);
    push(16'h7777);
    d0 = int'(ded_cnt);
    inject(base % DEPTH, 22'h000028);
    pop_chk("R6 double flag", 1'b0, 1'b1);
    chk("R6 ded_cnt after read", int'(ded_cnt), d0 + 1);
    pop_chk("R6 next word clean", 1'b1, 1'b0);
  endtask

  // R7: background scrub repairs storage once
  task automatic t_scrub();
    int base;
    int s0;
    base = n_wr;
    for (int i = 0; i < 4; i++) push(16'h9000 + 16'(i));
    s0 = int'(sec_cnt);
    inject((base + 2) % DEPTH, 22'h100000);
    idle(2 * DEPTH);
    chk("R7 scrub counted once", int'(sec_cnt), s0 + 1);
    for (int i = 0; i < 4; i++) pop_chk("R7 scrubbed data", 1'b1, 1'b0);
    chk("R7 no recount on read", int'(sec_cnt), s0 + 1);
  endtask

  // R8, R9, R10: double error left in place, counter saturates, clear
  task automatic t_saturate();
    int base;
    cnt_clr = 1'b1;
    tick();
    cnt_clr = 1'b0;
    chk("R10 clear sec", int'(sec_cnt), 0);
    base = n_wr;
    push(16'h4242);
    inject(base % DEPTH, 22'h0C0000);
    idle(300);
    chk("R8 R9 ded saturated", int'(ded_cnt), 255);
    chk("R8 no sec count", int'(sec_cnt), 0);
    cnt_clr = 1'b1;
    tick();
    cnt_clr = 1'b0;
    chk("R10 clear ded", int'(ded_cnt), 0);
    chk("R10 clear sec after", int'(sec_cnt), 0);
    pop_chk("R8 word left unchanged", 1'b0, 1'b1);
    chk("R8 read counted", int'(ded_cnt), 1);
  endtask

  // R11: upset in one pointer copy is harmless
  task automatic t_tmr();
    push(16'hAAAA);
    push(16'hBBBB);
    inj_ptr_en   = 1'b1;
    inj_ptr_mask = 5'h1F;
    push(16'hCCCC);
    inj_ptr_en   = 1'b0;
    inj_ptr_mask = 5'h00;
    inj_ptr_en   = 1'b1;
    inj_ptr_mask = 5'h0A;
    pop_chk("R11 order after upset", 1'b1, 1'b0);
    inj_ptr_en   = 1'b0;
    inj_ptr_mask = 5'h00;
    push(16'hDDDD);
    pop_chk("R11 order", 1'b1, 1'b0);
    pop_chk("R11 order", 1'b1, 1'b0);
    pop_chk("R11 order", 1'b1, 1'b0);
    #1;
    chk("R11 empty after", int'(rd_valid), 0);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0; n_wr = 0;
    rst_n = 1'b0;
    wr_valid = 1'b0; wr_data = '0; rd_get = 1'b0; cnt_clr = 1'b0;
    inj_mem_en = 1'b0; inj_addr = '0; inj_mask = '0;
    inj_ptr_en = 1'b0; inj_ptr_mask = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_fill();
    t_stream();
    t_sec_read();
    t_ded_read();
    t_scrub();
    t_saturate();
    t_tmr();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule